// File: doc/BRIEF.md
# Monitor Interrupt Aggregation Controller

This block collects condition flags from a hardware health monitor and turns them into one shared, active-low interrupt line. Three status registers hold the latched flags: a temperature group (local window, remote windows, thermal trip, remote diode faults), a tachometer group and a voltage group. Each group has its own mask. A small configuration register holds an enable bit and a clear bit, and together they act as a gate in front of the pin. A one-hot read strobe, raised by the register-access logic when software reads a status register, empties that register on the next clock edge.

The pin is open drain. The block drives a data value that is always zero, plus an output enable. An external pull-up supplies the released high level. Temperature window flags fire only when a reading crosses from inside its window to outside it. The thermal trip flag and the diode fault flags follow the live condition, cannot be masked, and come back at once if their condition persists across a clearing read.

Top module: `mon_irq_agg`

## Requirements
- R1: `irq_oe` is 1 exactly when the enable bit is 1, the clear bit is 0, and at least one status bit that counts towards the pin is set. `irq_o` is always 0.
- R2: After reset all three status registers are 0, the enable bit is 0 and the clear bit is 1, so `irq_oe` is 0 even if a flag is latched later. A write with `cfg_we` = 1 loads `cfg_en_d` and `cfg_clr_d` on the next edge.
- R3: `rd_stb` is one-hot by register: bit 0 selects the temperature status, bit 1 the tachometer status and bit 2 the voltage status. An asserted bit clears every bit of that register on the next edge and leaves the other registers unchanged.
- R4: Writing the enable and clear bits never changes any status register.
- R5: If a source event and a clearing read of the same register fall in the same cycle, the bit hit by the event is set after the edge.
- R6: Temperature status bit N_REMOTE+1 (bit 3 by default) is set on every edge where `trip_hit` is 1 or `ext_therm_n` is 0. It survives a clearing read while the condition lasts, and it counts towards the pin whatever its mask bit says.
- R7: Temperature status bits N_REMOTE+2 and up (bits 4 and 5 by default) follow `diode_fault[k]` in the same way. They are set while the fault is present, survive a clearing read while it lasts, and are unmaskable.
- R8: Temperature status bit 0 is set only on an edge where the local reading is outside the window (`loc_temp` < `loc_lo` or `loc_temp` > `loc_hi`, unsigned) and was inside it at the previous edge. A reading that stays outside does not set the bit again after a clear.
- R9: Remote channel k (reading `rem_temp[k*TW +: TW]`) sets temperature status bit 1+k by the same crossing rule, against the shared limits `rem_lo` and `rem_hi`.
- R10: `tach_err_in[k]` sets tachometer status bit k on the next edge unless `tach_disable[k]` is 1, in which case the input never sets the bit.
- R11: A mask bit of 1 keeps the matching status bit latched but removes it from the pin. This holds for all tachometer and voltage bits and for temperature bits 0..N_REMOTE.
- R12: `volt_err_in[k]` sets voltage status bit k on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_temp | input | TW | Local temperature reading |
| loc_lo | input | TW | Local window low limit |
| loc_hi | input | TW | Local window high limit |
| rem_temp | input | N_REMOTE*TW | Remote readings, channel k at bits k*TW |
| rem_lo | input | TW | Shared remote window low limit |
| rem_hi | input | TW | Shared remote window high limit |
| trip_hit | input | 1 | Internal trip-point comparison result |
| ext_therm_n | input | 1 | External thermal input, active low |
| diode_fault | input | N_REMOTE | Remote diode open/short flags |
| tach_err_in | input | N_TACH | Fan speed boundary violations |
| tach_disable | input | N_TACH | Per-input tachometer disable |
| volt_err_in | input | N_VOLT | Voltage trip-level violations |
| temp_mask | input | 2*N_REMOTE+2 | Temperature group mask |
| tach_mask | input | N_TACH | Tachometer group mask |
| volt_mask | input | N_VOLT | Voltage group mask |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_en_d | input | 1 | Enable bit write value |
| cfg_clr_d | input | 1 | Clear bit write value |
| rd_stb | input | 3 | One-hot status read strobe |
| temp_status | output | 2*N_REMOTE+2 | Temperature status register |
| tach_status | output | N_TACH | Tachometer status register |
| volt_status | output | N_VOLT | Voltage status register |
| irq_oe | output | 1 | Pin output enable (1 = drive low) |
| irq_o | output | 1 | Pin data value, tied to 0 |

## Verification
The hardest state to reach from the ports is a clearing read that lands while a persistent condition is still active. For the thermal trip and diode faults the bit must survive. For a temperature window the same read must leave the bit clear, because the reading is still outside and no new crossing has occurred. The stimulus holds `ext_therm_n` low, a diode fault or an out-of-window reading across a read strobe, with the relevant masks set so that only the unmaskable bits can hold the pin. The reading is then walked back inside and out through the opposite limit to show that a fresh crossing sets the bit again. A separate table step places a tachometer event in the same cycle as its register's read.

// File: rtl/mon_irq_pkg.sv
package mon_irq_pkg;

   // width of the temperature status group for a given remote channel count
   function automatic int temp_w(input int n_remote);
      return 2 * n_remote + 2;
   endfunction

   // bit index of the thermal trip flag in the temperature group
   function automatic int therm_bit(input int n_remote);
      return n_remote + 1;
   endfunction

   // one-hot read strobe lanes
   localparam int RD_TEMP = 0;
   localparam int RD_TACH = 1;
   localparam int RD_VOLT = 2;
   localparam int RD_W    = 3;

   typedef struct packed {
      logic en;
      logic clr;
   } irq_cfg_t;

   localparam irq_cfg_t CFG_RESET = '{en: 1'b0, clr: 1'b1};

endpackage

// File: rtl/mon_win_xing.sv
// Per-channel window crossing detector: pulses when a reading leaves its window.
module mon_win_xing #(
   parameter int N  = 1,
   parameter int TW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N*TW-1:0] rd_val,
   input  logic [N*TW-1:0] lim_lo,
   input  logic [N*TW-1:0] lim_hi,
   output logic [N-1:0]    leave
);

   logic [N-1:0] outside_now;
   logic [N-1:0] outside_q;

   for (genvar k = 0; k < N; k++) begin : g_ch
      logic [TW-1:0] v, lo, hi;
      assign v  = rd_val[k*TW +: TW];
      assign lo = lim_lo[k*TW +: TW];
      assign hi = lim_hi[k*TW +: TW];
      assign outside_now[k] = (v < lo) || (v > hi);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) outside_q <= '0;
      else        outside_q <= outside_now;
   end

   assign leave = outside_now & ~outside_q;

endmodule

// File: rtl/mon_stat_reg.sv
// Latched status group: set by events, emptied by a read strobe; events win.
module mon_stat_reg #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic         rd_clr,
   output logic [W-1:0] q
);

   logic [W-1:0] keep;

   assign keep = rd_clr ? '0 : q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= keep | set_i;
   end

endmodule

// File: rtl/mon_cfg_reg.sv
// Enable / clear gate register with defined reset values.
module mon_cfg_reg
   import mon_irq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     we,
   input  irq_cfg_t d,
   output irq_cfg_t q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= CFG_RESET;
      else if (we) q <= d;
   end

endmodule

// File: rtl/mon_ext_sync.sv
// Optional synchronizer for the asynchronous external thermal input.
module mon_ext_sync #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic a_n,
   output logic y_n
);

   if (STAGES > 4) begin : g_bad_stages
      $error("mon_ext_sync: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_direct
      assign y_n = a_n;
   end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '1;
         else        sh <= {sh[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], a_n};
      end
      assign y_n = sh[STAGES-1];
   end

endmodule

// File: rtl/mon_irq_agg.sv
module mon_irq_agg
   import mon_irq_pkg::*;
#(
   parameter int TW          = 8,
   parameter int N_REMOTE    = 2,
   parameter int N_TACH      = 6,
   parameter int N_VOLT      = 6,
   parameter int EXT_SYNC    = 0
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [TW-1:0]                     loc_temp,
   input  logic [TW-1:0]                     loc_lo,
   input  logic [TW-1:0]                     loc_hi,
   input  logic [N_REMOTE*TW-1:0]            rem_temp,
   input  logic [TW-1:0]                     rem_lo,
   input  logic [TW-1:0]                     rem_hi,
   input  logic                              trip_hit,
   input  logic                              ext_therm_n,
   input  logic [N_REMOTE-1:0]               diode_fault,
   input  logic [N_TACH-1:0]                 tach_err_in,
   input  logic [N_TACH-1:0]                 tach_disable,
   input  logic [N_VOLT-1:0]                 volt_err_in,
   input  logic [temp_w(N_REMOTE)-1:0]       temp_mask,
   input  logic [N_TACH-1:0]                 tach_mask,
   input  logic [N_VOLT-1:0]                 volt_mask,
   input  logic                              cfg_we,
   input  logic                              cfg_en_d,
   input  logic                              cfg_clr_d,
   input  logic [RD_W-1:0]                   rd_stb,
   output logic [temp_w(N_REMOTE)-1:0]       temp_status,
   output logic [N_TACH-1:0]                 tach_status,
   output logic [N_VOLT-1:0]                 volt_status,
   output logic                              irq_oe,
   output logic                              irq_o
);

   localparam int TSW    = temp_w(N_REMOTE);
   localparam int TH_BIT = therm_bit(N_REMOTE);
   localparam int NWIN   = N_REMOTE + 1;

   // elaboration-time parameter checks
   if (TW < 2) begin : g_bad_tw
      $error("mon_irq_agg: TW must be at least 2");
   end
   if (N_REMOTE < 1) begin : g_bad_rem
      $error("mon_irq_agg: N_REMOTE must be at least 1");
   end
   if (N_TACH < 1 || N_VOLT < 1) begin : g_bad_grp
      $error("mon_irq_agg: tachometer and voltage groups need at least one input");
   end

   // ---------------- window crossing (local + remotes) ----------------
   logic [NWIN*TW-1:0] win_val, win_lo, win_hi;
   logic [NWIN-1:0]    win_leave;

   assign win_val[TW-1:0] = loc_temp;
   assign win_lo[TW-1:0]  = loc_lo;
   assign win_hi[TW-1:0]  = loc_hi;
   for (genvar k = 0; k < N_REMOTE; k++) begin : g_rem_map
      assign win_val[(k+1)*TW +: TW] = rem_temp[k*TW +: TW];
      assign win_lo[(k+1)*TW +: TW]  = rem_lo;
      assign win_hi[(k+1)*TW +: TW]  = rem_hi;
   end

   mon_win_xing #(.N(NWIN), .TW(TW)) u_xing (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_val (win_val),
      .lim_lo (win_lo),
      .lim_hi (win_hi),
      .leave  (win_leave)
   );

   // ---------------- thermal trip source ----------------
   logic ext_n_s;
   logic therm_cond;

   mon_ext_sync #(.STAGES(EXT_SYNC)) u_ext (
      .clk   (clk),
      .rst_n (rst_n),
      .a_n   (ext_therm_n),
      .y_n   (ext_n_s)
   );

   assign therm_cond = trip_hit | ~ext_n_s;

   // ---------------- event vectors per group ----------------
   logic [TSW-1:0]    temp_set;
   logic [N_TACH-1:0] tach_set;
   logic [N_VOLT-1:0] volt_set;

   assign temp_set = {diode_fault, therm_cond, win_leave};
   assign tach_set = tach_err_in & ~tach_disable;
   assign volt_set = volt_err_in;

   // ---------------- status registers ----------------
   mon_stat_reg #(.W(TSW)) u_st_temp (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (temp_set),
      .rd_clr (rd_stb[RD_TEMP]),
      .q      (temp_status)
   );

   mon_stat_reg #(.W(N_TACH)) u_st_tach (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (tach_set),
      .rd_clr (rd_stb[RD_TACH]),
      .q      (tach_status)
   );

   mon_stat_reg #(.W(N_VOLT)) u_st_volt (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (volt_set),
      .rd_clr (rd_stb[RD_VOLT]),
      .q      (volt_status)
   );

   // ---------------- configuration gate ----------------
   irq_cfg_t cfg_q;
   irq_cfg_t cfg_d;
   logic     cfg_en_q, cfg_clr_q;

   assign cfg_d = '{en: cfg_en_d, clr: cfg_clr_d};

   mon_cfg_reg u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .d     (cfg_d),
      .q     (cfg_q)
   );

   assign cfg_en_q  = cfg_q.en;
   assign cfg_clr_q = cfg_q.clr;

   // ---------------- masking and pin ----------------
   // thermal trip and diode fault bits ignore their mask bits
   logic [TSW-1:0] temp_mask_eff;
   for (genvar b = 0; b < TSW; b++) begin : g_tmask
      if (b >= TH_BIT) begin : g_unmaskable
         assign temp_mask_eff[b] = 1'b0;
      end else begin : g_maskable
         assign temp_mask_eff[b] = temp_mask[b];
      end
   end

   logic any_pending;
   assign any_pending = |(temp_status & ~temp_mask_eff)
                      | |(tach_status & ~tach_mask)
                      | |(volt_status & ~volt_mask);

   assign irq_oe = cfg_en_q & ~cfg_clr_q & any_pending;
   assign irq_o  = 1'b0;

endmodule

// File: rtl/mon_irq_agg_chk.sv
module mon_irq_agg_chk #(
   parameter int TW       = 8,
   parameter int N_REMOTE = 2,
   parameter int N_TACH   = 6,
   parameter int N_VOLT   = 6
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [TW-1:0]         loc_temp,
   input logic [TW-1:0]         loc_lo,
   input logic [TW-1:0]         loc_hi,
   input logic                  trip_hit,
   input logic [N_TACH-1:0]     tach_err_in,
   input logic [N_TACH-1:0]     tach_disable,
   input logic [N_VOLT-1:0]     volt_mask,
   input logic [2:0]            rd_stb,
   input logic [2*N_REMOTE+1:0] temp_status,
   input logic [N_TACH-1:0]     tach_status,
   input logic [N_VOLT-1:0]     volt_status,
   input logic                  irq_oe,
   input logic                  cfg_en_q,
   input logic                  cfg_clr_q
);

   localparam int TH_BIT = N_REMOTE + 1;

   // R1: gate closed means pin released
   p_pin_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_en_q || cfg_clr_q) |-> !irq_oe);

   // R11: an unmasked voltage flag with the gate open pulls the pin
   p_mask_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_en_q && !cfg_clr_q && ((volt_status & ~volt_mask) != '0)) |-> irq_oe);

   // R3: a tachometer read with no event in that cycle empties the register
   p_rd_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb[1] && ((tach_err_in & ~tach_disable) == '0)) |=> (tach_status == '0));

   // R3: without a read, no voltage bit falls
   p_keep_unread_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb[2] |=> (($past(volt_status) & ~volt_status) == '0));

   // R5: event beats a same-cycle read
   p_event_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb[1] && tach_err_in[0] && !tach_disable[0]) |=> tach_status[0]);

   // R6: trip comparison latches the thermal bit, which then holds the open gate
   p_trip_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      trip_hit |=> temp_status[TH_BIT]);

   p_trip_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_en_q && !cfg_clr_q && temp_status[TH_BIT]) |-> irq_oe);

   // R8: the local flag only rises after an outside reading
   p_ltv_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(temp_status[0]) |-> $past((loc_temp < loc_lo) || (loc_temp > loc_hi)));

   // R10: a disabled tachometer input never raises its bit
   p_tach_dis_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((tach_status & ~$past(tach_status) & $past(tach_disable)) == '0));

endmodule

bind mon_irq_agg mon_irq_agg_chk #(
   .TW(TW), .N_REMOTE(N_REMOTE), .N_TACH(N_TACH), .N_VOLT(N_VOLT)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .loc_temp     (loc_temp),
   .loc_lo       (loc_lo),
   .loc_hi       (loc_hi),
   .trip_hit     (trip_hit),
   .tach_err_in  (tach_err_in),
   .tach_disable (tach_disable),
   .volt_mask    (volt_mask),
   .rd_stb       (rd_stb),
   .temp_status  (temp_status),
   .tach_status  (tach_status),
   .volt_status  (volt_status),
   .irq_oe       (irq_oe),
   .cfg_en_q     (cfg_en_q),
   .cfg_clr_q    (cfg_clr_q)
);

// File: tb/mon_irq_agg_test.sv
`timescale 1ns/1ps
module mon_irq_agg_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  loc_temp = 8'd50, loc_lo = 8'd20, loc_hi = 8'd80;
   logic [15:0] rem_temp = {8'd50, 8'd50};
   logic [7:0]  rem_lo = 8'd20, rem_hi = 8'd80;
   logic        trip_hit = 1'b0, ext_therm_n = 1'b1;
   logic [1:0]  diode_fault = '0;
   logic [5:0]  tach_err_in = '0, tach_disable = '0, volt_err_in = '0;
   logic [5:0]  temp_mask = '0, tach_mask = '0, volt_mask = '0;
   logic        cfg_we = 1'b0, cfg_en_d = 1'b0, cfg_clr_d = 1'b0;
   logic [2:0]  rd_stb = '0;
   logic [5:0]  temp_status, tach_status, volt_status;
   logic        irq_oe, irq_o;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;   // 50 MHz

   mon_irq_agg uut (
      .clk(clk), .rst_n(rst_n),
      .loc_temp(loc_temp), .loc_lo(loc_lo), .loc_hi(loc_hi),
      .rem_temp(rem_temp), .rem_lo(rem_lo), .rem_hi(rem_hi),
      .trip_hit(trip_hit), .ext_therm_n(ext_therm_n), .diode_fault(diode_fault),
      .tach_err_in(tach_err_in), .tach_disable(tach_disable), .volt_err_in(volt_err_in),
      .temp_mask(temp_mask), .tach_mask(tach_mask), .volt_mask(volt_mask),
      .cfg_we(cfg_we), .cfg_en_d(cfg_en_d), .cfg_clr_d(cfg_clr_d), .rd_stb(rd_stb),
      .temp_status(temp_status), .tach_status(tach_status), .volt_status(volt_status),
      .irq_oe(irq_oe), .irq_o(irq_o)
   );

   // vector: tin tdis tmask vin vmask rd | exp_tach exp_volt exp_oe
   localparam int NV = 11;
   localparam logic [45:0] VEC [NV] = '{
      {6'h01, 6'h00, 6'h00, 6'h00, 6'h00, 3'b000, 6'h01, 6'h00, 1'b1},  // R10 tach sets
      {6'h00, 6'h00, 6'h00, 6'h00, 6'h00, 3'b010, 6'h00, 6'h00, 1'b0},  // R3 read tach
      {6'h20, 6'h20, 6'h00, 6'h00, 6'h00, 3'b000, 6'h00, 6'h00, 1'b0},  // R10 disabled
      {6'h00, 6'h00, 6'h00, 6'h04, 6'h04, 3'b000, 6'h00, 6'h04, 1'b0},  // R11 masked latch
      {6'h00, 6'h00, 6'h00, 6'h00, 6'h00, 3'b000, 6'h00, 6'h04, 1'b1},  // R11 unmask
      {6'h02, 6'h00, 6'h00, 6'h00, 6'h00, 3'b010, 6'h02, 6'h04, 1'b1},  // R5 event wins
      {6'h00, 6'h00, 6'h00, 6'h00, 6'h00, 3'b100, 6'h02, 6'h00, 1'b1},  // R3 read volt only
      {6'h00, 6'h00, 6'h02, 6'h00, 6'h00, 3'b000, 6'h02, 6'h00, 1'b0},  // R11 tach mask
      {6'h00, 6'h00, 6'h00, 6'h00, 6'h00, 3'b010, 6'h00, 6'h00, 1'b0},  // R3
      {6'h3F, 6'h00, 6'h00, 6'h3F, 6'h00, 3'b000, 6'h3F, 6'h3F, 1'b1},  // R12 all set
      {6'h00, 6'h00, 6'h00, 6'h00, 6'h00, 3'b110, 6'h00, 6'h00, 1'b0}   // R3 read both
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic cfg_write(input logic en, input logic clr);
      cfg_we = 1'b1; cfg_en_d = en; cfg_clr_d = clr;
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic read_reg(input logic [2:0] sel);
      rd_stb = sel;
      tick();
      rd_stb = '0;
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 reset state
      chk("R2 temp_status reset", temp_status, 0);
      chk("R2 tach_status reset", tach_status, 0);
      chk("R2 volt_status reset", volt_status, 0);
      chk("R1 irq_oe reset", irq_oe, 0);
      chk("R1 irq_o tied low", irq_o, 0);

      // R2 default gate keeps pin released although a flag latches
      tach_err_in = 6'h01; tick(); tach_err_in = '0;
      chk("R2 flag latched", tach_status, 6'h01);
      chk("R2 pin released by default gate", irq_oe, 0);
      cfg_write(1'b1, 1'b1);
      chk("R1 clear bit gates pin", irq_oe, 0);
      chk("R4 status kept after cfg write", tach_status, 6'h01);
      cfg_write(1'b1, 1'b0);
      chk("R1 pin driven with gate open", irq_oe, 1);
      cfg_write(1'b0, 1'b0);
      chk("R1 enable low releases pin", irq_oe, 0);
      chk("R4 status kept after disable", tach_status, 6'h01);
      cfg_write(1'b1, 1'b0);
      read_reg(3'b010);
      chk("R3 tach cleared", tach_status, 0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         logic [45:0] v;
         v = VEC[i];
         tach_err_in  = v[45:40];
         tach_disable = v[39:34];
         tach_mask    = v[33:28];
         volt_err_in  = v[27:22];
         volt_mask    = v[21:16];
         rd_stb       = v[15:13];
         tick();
         tach_err_in = '0; volt_err_in = '0; rd_stb = '0;
         chk($sformatf("R3/R5/R10/R11/R12 vec%0d tach", i), tach_status, v[12:7]);
         chk($sformatf("R3/R11/R12 vec%0d volt", i), volt_status, v[6:1]);
         chk($sformatf("R1/R11 vec%0d pin", i), irq_oe, v[0]);
      end
      tach_disable = '0; tach_mask = '0; volt_mask = '0;

      // R8 local crossing above high limit
      loc_temp = 8'd90; tick();
      chk("R8 local crossing sets bit0", temp_status, 6'h01);
      chk("R1 pin from local crossing", irq_oe, 1);
      read_reg(3'b001);
      chk("R8 cleared while staying outside", temp_status, 0);
      tick(); tick(); tick();
      chk("R8 no re-set while outside", temp_status, 0);
      chk("R8 pin released while outside", irq_oe, 0);
      loc_temp = 8'd50; tick();
      chk("R8 return inside sets nothing", temp_status, 0);
      loc_temp = 8'd10; tick();
      chk("R8 crossing below low limit", temp_status, 6'h01);
      loc_temp = 8'd50; read_reg(3'b001);

      // R9 remote channel 1
      rem_temp[15:8] = 8'd90; tick();
      chk("R9 remote ch1 sets bit2", temp_status, 6'h04);
      rem_temp[15:8] = 8'd50; read_reg(3'b001);
      chk("R9 cleared", temp_status, 0);

      // R11 masked temperature flag, R6 unmaskable thermal
      temp_mask = 6'h3F;
      rem_temp[7:0] = 8'd5; tick();
      chk("R11 masked remote bit latched", temp_status, 6'h02);
      chk("R11 masked remote keeps pin released", irq_oe, 0);
      ext_therm_n = 1'b0; tick();
      chk("R6 external thermal sets bit3", temp_status, 6'h0A);
      chk("R6 thermal bypasses mask", irq_oe, 1);
      read_reg(3'b001);
      chk("R6 thermal survives read", temp_status, 6'h08);
      chk("R6 pin re-asserted", irq_oe, 1);
      ext_therm_n = 1'b1; rem_temp[7:0] = 8'd50; read_reg(3'b001);
      chk("R6 thermal cleared after release", temp_status, 0);
      chk("R1 pin released", irq_oe, 0);
      trip_hit = 1'b1; tick(); trip_hit = 1'b0;
      chk("R6 trip comparison sets bit3", temp_status, 6'h08);
      chk("R6 trip pin", irq_oe, 1);
      read_reg(3'b001);

      // R7 diode fault
      diode_fault = 2'b10; tick();
      chk("R7 fault ch1 sets bit5", temp_status, 6'h20);
      chk("R7 fault bypasses mask", irq_oe, 1);
      read_reg(3'b001);
      chk("R7 fault survives read", temp_status, 6'h20);
      diode_fault = 2'b00; read_reg(3'b001);
      chk("R7 fault cleared after release", temp_status, 0);
      chk("R7 pin released", irq_oe, 0);
      temp_mask = '0;

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule